// File: doc/BRIEF.md
# Parallel-Port Forward Byte Handshake Engine

This block moves bytes from a host toward a peripheral over an 8-bit parallel bus. The host writes bytes into a 16-entry queue, and each byte carries a tag that marks it as a data byte or a command byte. A command byte can hold a channel address or a run-length count. The engine takes bytes from the queue one at a time and presents each one on the bus. Every transfer is paced by a fully interlocked strobe/busy exchange, so the peripheral sets the rate. No free-running strobe is used.

On the host side there is a byte-wide write port with a command tag, full and empty flags, and a 2-bit status field in the layout of an extended control register. On the peripheral side the engine drives an active-low strobe, the data bus and an active-low command/data qualifier, and it samples a busy input through a synchronizer.

A transfer runs as follows. The engine takes a byte only while busy is seen low. It drives the bus and waits at least one clock of setup, then pulls the strobe low. It holds the strobe low until it sees busy high, then releases the strobe. It does not take the next byte until busy has fallen again.

Top module: `pp_fwd_xfer`

## Requirements
- R1: The queue stores up to 16 entries. `fifo_full` is 1 exactly when 16 entries are stored, and `fifo_empty` is 1 exactly when none are stored. The two flags are never 1 together.
- R2: A write (`wr_en`=1) while `fifo_full` is 1 is dropped. The queue contents do not change, and `fifo_full` stays 1 until an entry is taken out.
- R3: `xstat[0]` equals the empty flag and `xstat[1]` equals the full flag.
- R4: While the queue is empty, `strobe_n` stays 1 and no strobe pulse is produced.
- R5: `busy` passes through a 2-flop synchronizer. An entry is taken out of the queue only in a cycle where the synchronized busy is 0.
- R6: `pd_out` changes when an entry is taken out. It holds that value for at least SETUP_CYC clocks (default 1) before `strobe_n` falls, and it stays stable while `strobe_n` is 0.
- R7: `strobe_n` returns to 1 only after the synchronized busy has been seen at 1. The next entry is not taken until the synchronized busy has been seen at 0 again.
- R8: `autofd_n` is 1 for a data byte (`wr_cmd`=0) and 0 for a command byte (`wr_cmd`=1). It stays stable while `strobe_n` is 0.
- R9: Bytes reach the bus in the order they were accepted, each with its own tag.
- R10: After reset the outputs are `strobe_n`=1, `autofd_n`=1, `pd_out`=0, `fifo_empty`=1, `fifo_full`=0 and `xstat`=2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the host port |
| wr_byte | input | 8 | Byte to be queued |
| wr_cmd | input | 1 | 1 = command byte, 0 = data byte |
| fifo_full | output | 1 | Queue holds 16 entries |
| fifo_empty | output | 1 | Queue holds no entries |
| xstat | output | 2 | Status field: bit0 empty, bit1 full |
| pd_out | output | 8 | Parallel data bus |
| strobe_n | output | 1 | Active-low byte strobe |
| autofd_n | output | 1 | Command/data qualifier (0 = command) |
| busy | input | 1 | Peripheral busy, asynchronous |

## Verification
The engine is driven with a peripheral responder at several pacings:
- a fast one that answers after one clock;
- a slow one that holds the strobe low and busy high for several clocks;
- a held-busy case in which the peripheral never becomes ready.

The fast and slow pacings separate a correct interlock from a design that times its strobe by a counter. The held-busy case shows whether the engine wrongly starts a byte while busy is high. Mixed command and data sequences check that the qualifier follows its byte, and a burst of 18 writes against a stalled bus shows the full boundary and the dropped writes. An idle stretch on an empty queue exposes spurious strobes.

// File: rtl/pp_fwd_pkg.sv
package pp_fwd_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic              is_cmd;
    logic [BYTE_W-1:0] value;
  } fwd_ent_t;

  typedef enum logic [1:0] {
    HS_IDLE    = 2'd0,
    HS_SETUP   = 2'd1,
    HS_STROBE  = 2'd2,
    HS_RELEASE = 2'd3
  } hs_state_e;
endpackage

// File: rtl/pp_fwd_rst_sync.sv
module pp_fwd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-2:0], 1'b1};
  end

  assign rst_no = q[STAGES-1];
endmodule

// File: rtl/pp_fwd_sync.sv
module pp_fwd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  // resets to 1 so the engine treats the peripheral as not ready
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chain <= '1;
    else         chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pp_fwd_fifo.sv
module pp_fwd_fifo
  import pp_fwd_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic     clk,
  input  logic     rst_ni,
  input  logic     push,
  input  fwd_ent_t push_data,
  input  logic     pop,
  output fwd_ent_t head,
  output logic     full,
  output logic     empty
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  fwd_ent_t      mem [DEPTH];
  logic [PW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_ok, rd_ok;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign wr_ok = push && !full;
  assign rd_ok = pop && !empty;
  assign head  = mem[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (wr_ok) wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
    if (rd_ok) rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
    case ({wr_ok, rd_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (wr_ok)          wr_ptr_q <= wr_ptr_d;
      if (rd_ok)          rd_ptr_q <= rd_ptr_d;
      if (wr_ok ^ rd_ok)  cnt_q    <= cnt_d;
    end
  end

  // storage carries no reset
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr_q] <= push_data;
  end
endmodule

// File: rtl/pp_fwd_hs.sv
module pp_fwd_hs
  import pp_fwd_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  fwd_ent_t          head,
  input  logic              head_valid,
  input  logic              busy_s,
  output logic              pop,
  output logic [BYTE_W-1:0] pd,
  output logic              strobe_n,
  output logic              autofd_n
);
  localparam int unsigned SW = (SETUP_CYC > 1) ? $clog2(SETUP_CYC) : 1;

  hs_state_e         st_q, st_d;
  logic [BYTE_W-1:0] pd_q, pd_d;
  logic              cmd_q, cmd_d;
  logic              stb_q, stb_d;
  logic [SW-1:0]     cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    pd_d  = pd_q;
    cmd_d = cmd_q;
    stb_d = stb_q;
    cnt_d = cnt_q;
    pop   = 1'b0;
    case (st_q)
      HS_IDLE: begin
        if (head_valid && !busy_s) begin
          pop   = 1'b1;
          pd_d  = head.value;
          cmd_d = head.is_cmd;
          cnt_d = SW'(SETUP_CYC - 1);
          st_d  = HS_SETUP;
        end
      end
      HS_SETUP: begin
        if (cnt_q == '0) begin
          stb_d = 1'b0;
          st_d  = HS_STROBE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      HS_STROBE: begin
        if (busy_s) begin
          stb_d = 1'b1;
          st_d  = HS_RELEASE;
        end
      end
      default: begin
        if (!busy_s) st_d = HS_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= HS_IDLE;
      pd_q  <= '0;
      cmd_q <= 1'b0;
      stb_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      stb_q <= stb_d;
      cnt_q <= cnt_d;
      if (pop) begin
        pd_q  <= pd_d;
        cmd_q <= cmd_d;
      end
    end
  end

  assign pd       = pd_q;
  assign strobe_n = stb_q;
  assign autofd_n = ~cmd_q;
endmodule

// File: rtl/pp_fwd_xfer.sv
module pp_fwd_xfer
  import pp_fwd_pkg::*;
#(
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned SETUP_CYC   = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              wr_cmd,
  output logic              fifo_full,
  output logic              fifo_empty,
  output logic [1:0]        xstat,
  output logic [BYTE_W-1:0] pd_out,
  output logic              strobe_n,
  output logic              autofd_n,
  input  logic              busy
);
  logic     rst_int_n;
  logic     busy_s;
  logic     pop;
  fwd_ent_t head;
  fwd_ent_t wr_ent;

  assign wr_ent.is_cmd = wr_cmd;
  assign wr_ent.value  = wr_byte;

  pp_fwd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_ni(rst_n), .rst_no(rst_int_n)
  );

  pp_fwd_sync #(.STAGES(SYNC_STAGES)) u_busy (
    .clk(clk), .rst_ni(rst_int_n), .d(busy), .q(busy_s)
  );

  pp_fwd_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_ni(rst_int_n),
    .push(wr_en), .push_data(wr_ent),
    .pop(pop), .head(head),
    .full(fifo_full), .empty(fifo_empty)
  );

  pp_fwd_hs #(.SETUP_CYC(SETUP_CYC)) u_hs (
    .clk(clk), .rst_ni(rst_int_n),
    .head(head), .head_valid(!fifo_empty), .busy_s(busy_s),
    .pop(pop), .pd(pd_out), .strobe_n(strobe_n), .autofd_n(autofd_n)
  );

  // status field: bit 0 empty, bit 1 full
  assign xstat = {fifo_full, fifo_empty};
endmodule

module pp_fwd_xfer_chk (
  input logic       clk,
  input logic       rst_ni,
  input logic [7:0] pd_out,
  input logic       strobe_n,
  input logic       autofd_n,
  input logic       fifo_full,
  input logic       fifo_empty,
  input logic       busy_s,
  input logic       pop
);
  assert_flags_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    !(fifo_full && fifo_empty));

  assert_full_holds_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(fifo_full) && !$past(pop)) |-> fifo_full);

  assert_no_pop_empty_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    pop |-> !fifo_empty);

  assert_no_pop_busy_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    pop |-> !busy_s);

  assert_bus_stable_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    !strobe_n |-> $stable(pd_out));

  assert_release_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(strobe_n) |-> $past(busy_s));

  assert_tag_stable_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    !strobe_n |-> $stable(autofd_n));
endmodule

bind pp_fwd_xfer pp_fwd_xfer_chk chk_i (
  .clk(clk), .rst_ni(rst_int_n), .pd_out(pd_out), .strobe_n(strobe_n),
  .autofd_n(autofd_n), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
  .busy_s(busy_s), .pop(pop)
);

// File: tb/pp_fwd_xfer_tb_top.sv
module pp_fwd_xfer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic       wr_cmd = 1'b0;
  logic       busy = 1'b0;
  logic       fifo_full, fifo_empty, strobe_n, autofd_n;
  logic [1:0] xstat;
  logic [7:0] pd_out;

  always #4 clk = ~clk;

  pp_fwd_xfer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_byte(wr_byte), .wr_cmd(wr_cmd),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .xstat(xstat),
    .pd_out(pd_out), .strobe_n(strobe_n), .autofd_n(autofd_n), .busy(busy)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model, advanced on every rising edge
  int         m_state;
  logic [8:0] mq[$];
  bit         m_r1, m_r2, m_b1, m_b2;
  logic       m_stb, m_afd;
  logic [7:0] m_pd;

  always @(posedge clk or negedge rst_n) begin
    logic [8:0] ent;
    bit         was_full;
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0; m_state = 0; m_stb = 1; m_pd = 0; m_afd = 1;
      mq.delete(); m_b1 = 1; m_b2 = 1;
    end else begin
      if (!m_r2) begin
        m_state = 0; m_stb = 1; m_pd = 0; m_afd = 1;
        mq.delete(); m_b1 = 1; m_b2 = 1;
      end else begin
        was_full = (mq.size() == 16);
        case (m_state)
          0: if (mq.size() > 0 && !m_b2) begin
               ent = mq.pop_front();
               m_pd = ent[7:0]; m_afd = ~ent[8]; m_state = 1;
             end
          1: begin m_stb = 0; m_state = 2; end
          2: if (m_b2) begin m_stb = 1; m_state = 3; end
          default: if (!m_b2) m_state = 0;
        endcase
        if (wr_en && !was_full) mq.push_back({wr_cmd, wr_byte});
        m_b2 = m_b1; m_b1 = busy;
      end
      m_r2 = m_r1; m_r1 = 1;
    end
  end

  // scoreboard, responder and per-cycle comparison
  logic [8:0] sb[$];
  bit   hold_busy = 0;
  int   d1 = 1, d2 = 1;
  int   ph = 0, pc = 0;
  logic prev_stb = 1'b1;
  int   strobes = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R7 strobe_n", strobe_n, m_stb);
      chk("R6 pd_out", pd_out, m_pd);
      chk("R8 autofd_n", autofd_n, m_afd);
      chk("R1 fifo_full", fifo_full, (mq.size() == 16));
      chk("R4 fifo_empty", fifo_empty, (mq.size() == 0));
      chk("R3 xstat", xstat, {mq.size() == 16, mq.size() == 0});
      if (!strobe_n && prev_stb) begin
        strobes++;
        if (sb.size() == 0) chk("R9 unexpected strobe", 1, 0);
        else chk("R9 byte order", {~autofd_n, pd_out}, sb.pop_front());
      end
      prev_stb = strobe_n;
      if (hold_busy) begin
        busy = 1'b1; ph = 0;
      end else begin
        case (ph)
          0: begin busy = 1'b0; if (!strobe_n) begin pc = d1; ph = 1; end end
          1: if (pc <= 1) begin busy = 1'b1; ph = 2; end else pc--;
          2: if (strobe_n) begin pc = d2; ph = 3; end
          default: if (pc <= 1) begin busy = 1'b0; ph = 0; end else pc--;
        endcase
      end
    end
  end

  task automatic put(input bit cmd, input logic [7:0] b, input bit accept);
    @(negedge clk);
    wr_en = 1'b1; wr_cmd = cmd; wr_byte = b;
    if (accept) sb.push_back({cmd, b});
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    wr_en = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic drain();
    int guard = 0;
    idle(2);
    while ((sb.size() != 0 || !strobe_n || busy) && guard < 2000) begin
      @(negedge clk); guard++;
    end
    idle(4);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 strobe_n", strobe_n, 1);
    chk("R10 autofd_n", autofd_n, 1);
    chk("R10 pd_out", pd_out, 0);
    chk("R10 empty/full", {fifo_full, fifo_empty}, 2'b01);
    chk("R10 xstat", xstat, 2'b01);

    // R4: idle on empty queue gives no strobes
    s0 = strobes;
    idle(30);
    chk("R4 no strobe while empty", strobes - s0, 0);

    // fast peripheral, mixed tags (R8, R9)
    d1 = 1; d2 = 1;
    put(1, 8'h01, 1); put(0, 8'hA5, 1); put(0, 8'h5A, 1); put(1, 8'h83, 1);
    drain();

    // R5: busy held high, nothing starts
    hold_busy = 1;
    idle(6);
    s0 = strobes;
    put(0, 8'h11, 1); put(1, 8'h22, 1);
    idle(25);
    chk("R5 no strobe while busy", strobes - s0, 0);
    hold_busy = 0;
    drain();

    // R1/R2: fill to 16 against a stalled bus, 2 extra writes dropped
    hold_busy = 1;
    idle(6);
    for (int i = 0; i < 16; i++) put(i[0], 8'(8'h40 + i), 1);
    idle(2);
    chk("R1 full after 16 writes", fifo_full, 1);
    put(0, 8'hEE, 0); put(1, 8'hEF, 0);
    idle(2);
    chk("R2 still full after dropped writes", fifo_full, 1);
    chk("R3 xstat full", xstat, 2'b10);
    s0 = strobes;
    d1 = 4; d2 = 6;
    hold_busy = 0;
    drain();
    chk("R2 only 16 bytes delivered", strobes - s0, 16);

    // slow peripheral with writes during transfers (R6, R7, R9)
    d1 = 3; d2 = 2;
    for (int i = 0; i < 10; i++) begin
      put(i % 3 == 0, 8'(8'hC0 ^ (i * 7)), 1);
      idle(i % 4 + 1);
    end
    drain();
    chk("R9 scoreboard empty", sb.size(), 0);
    chk("R4 empty at end", fifo_empty, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule